// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds several independent down-counters behind one small synchronous register port. Each channel has a control word, an interval value and a readable count. Software arms a channel by writing the interval and then a control word with the enable and load-request bits set. The channel then counts down once per divided tick from the tick source it has selected. When it expires, it either restarts from the interval or stops and clears its own enable bit.

Time sources arrive as single-cycle tick strobes on `src_tick`, so the counters run in the bus clock domain. A per-channel binary prescaler divides the chosen strobe. The shared registers hold an interrupt-enable mask and a write-one-to-clear status word. One registered interrupt line is raised while any enabled status bit is set. A channel set to reload its full-width interval and left running gives a free-running count. The inverse of that count rises monotonically and can serve as a timestamp.

Top module: `cdtimer_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The shared registers sit at 0x00 (interrupt enable) and 0x04 (status), with channel n at bit n. Channel n has its control word at 0x10*n+0x10, its interval at 0x10*n+0x14 and its count at 0x10*n+0x18. Control word fields: bit 0 enable, bit 1 load request, bits 3:2 source select, bits 6:4 prescale exponent, bit 7 single-shot (1) or repeating (0).
- R3: A control write with the load-request bit set copies the interval into the count on the next clock. The load-request bit then reads back 0.
- R4: While enabled, the count drops by exactly one on each divided tick.
- R5: A prescale exponent N yields one divided tick per 2^N strobes of the selected source. Strobes on other sources have no effect on the channel.
- R6: A divided tick with count 1 sets the channel's status bit. In single-shot mode the count becomes 0, the enable bit clears, and further strobes leave the count at 0.
- R7: In repeating mode, a divided tick with count 1 reloads the interval and counting goes on.
- R8: Writing enable = 0 freezes the count at once, which is within the 2-tick bound. Later strobes leave the count unchanged.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry and a clear fall in the same cycle, the expiry wins.
- R10: `irq` is the registered OR over channels of status AND enable, one clock after the status and enable values.
- R11: An interval of 0xFFFFFFFF in repeating mode counts freely, so the bitwise inverse of the count equals the number of divided ticks elapsed.
- R12: Read data is registered and valid the clock after `bus_re`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_tick | input | 4 | Tick strobes of the four selectable time sources |
| irq | output | 1 | Registered interrupt request |

## Verification
The counters are driven in four ways: single strobes on the selected source at divide-by-one, strobes split between the selected and unselected sources with a prescale of 4, a disabled channel that still receives strobes, and a full-width interval. The single-strobe runs separate single-shot from repeating behaviour at the 1-to-0 boundary. The split-source run shows that both the prescaler phase and the source selection hold. Status clears are tried with zero and one data bits on both channels, and different enable masks are applied. This shows that the interrupt line follows status AND enable per bit position, not either one alone.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int NUM_SRC   = 4;
  localparam int SEL_W     = 2;
  localparam int PRES_W    = 3;
  localparam int CH_STRIDE = 16;
  localparam int IEN_OFF   = 0;
  localparam int STS_OFF   = 4;
  localparam int CTRL_REL  = 0;
  localparam int INTV_REL  = 4;
  localparam int CNT_REL   = 8;

  typedef struct packed {
    logic              oneshot;
    logic [PRES_W-1:0] pres;
    logic [SEL_W-1:0]  src;
    logic              reload;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  input  logic [PRES_W-1:0]  pres,
  output logic               tick
);
  localparam int DIV_W = (1 << PRES_W) - 1;

  logic [DIV_W-1:0] pc_q;
  logic [DIV_W-1:0] mask;
  logic             pick;

  always_comb begin
    pick = src_tick[sel];
    mask = ~({DIV_W{1'b1}} << pres);
    tick = pick && ((pc_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pc_q <= '0;
    else if (pick)  pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  ctrl_t              ctrl_wd,
  input  logic               intv_we,
  input  logic [CNT_W-1:0]   intv_wd,
  input  logic [NUM_SRC-1:0] src_tick,
  output ctrl_t              ctrl_q,
  output logic [CNT_W-1:0]   intv_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               expire
);
  logic div_tick;
  logic tick;

  cdt_prescaler u_pres (
    .clk      (clk),
    .rst      (rst),
    .clr      (!ctrl_q.en || ctrl_q.reload),
    .src_tick (src_tick),
    .sel      (ctrl_q.src),
    .pres     (ctrl_q.pres),
    .tick     (div_tick)
  );

  always_comb begin
    tick   = div_tick && ctrl_q.en && !ctrl_q.reload;
    expire = tick && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we)                         ctrl_q        <= ctrl_wd;
      else if (ctrl_q.reload)              ctrl_q.reload <= 1'b0;
      else if (expire && ctrl_q.oneshot)   ctrl_q.en     <= 1'b0;
      if (intv_we) intv_q <= intv_wd;
      if (ctrl_q.reload)                   cnt_q <= intv_q;
      else if (tick) begin
        if (cnt_q > CNT_W'(1))             cnt_q <= cnt_q - 1'b1;
        else if (ctrl_q.oneshot)           cnt_q <= '0;
        else                               cnt_q <= intv_q;
      end
    end
  end

  // R3: load request is consumed in one cycle and lands the interval
  a_r3_reload_clears: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.reload && !ctrl_we) |=> (!ctrl_q.reload && cnt_q == $past(intv_q)));
  // R8: a disabled channel with no load pending holds its count
  a_r8_disabled_holds: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !ctrl_q.reload) |=> $stable(cnt_q));
  // R6: single-shot expiry stops the channel
  a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q.oneshot && !ctrl_we) |=> (!ctrl_q.en && cnt_q == '0));
  // R7: repeating expiry reloads the interval
  a_r7_periodic_reloads: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctrl_q.oneshot && !intv_we) |=> (cnt_q == $past(intv_q)));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ien_we,
  input  logic              sts_we,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] ien_q,
  output logic [NUM_CH-1:0] sts_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      sts_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (ien_we) ien_q <= wbits;
      sts_q <= (sts_q & ~(sts_we ? wbits : '0)) | expire;
      irq   <= |(sts_q & ien_q);
    end
  end

  // R6: an expiry always leaves its status bit set
  a_r6_expire_sets: assert property (@(posedge clk) disable iff (rst)
    (expire != '0) |=> ((sts_q & $past(expire)) == $past(expire)));
  // R9: a one written to a bit with no concurrent expiry clears it
  a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
    (sts_we && expire == '0) |=> ((sts_q & $past(wbits)) == '0));
  // R10: with the mask empty for two cycles the line stays low
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0 && $past(ien_q) == '0) |-> !irq);
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
  import cdt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ch_ctrl [NUM_CH];
  logic [CNT_W-1:0]  ch_intv [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
  logic [NUM_CH-1:0] ch_exp;
  logic [NUM_CH-1:0] ien, sts;
  logic [CNT_W-1:0]  rd_mux;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = CH_STRIDE * (c + 1);
    cdt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ctrl_we  (bus_we && bus_addr == ADDR_W'(BASE + CTRL_REL)),
      .ctrl_wd  (ctrl_t'(bus_wdata[CTRL_W-1:0])),
      .intv_we  (bus_we && bus_addr == ADDR_W'(BASE + INTV_REL)),
      .intv_wd  (bus_wdata),
      .src_tick (src_tick),
      .ctrl_q   (ch_ctrl[c]),
      .intv_q   (ch_intv[c]),
      .cnt_q    (ch_cnt[c]),
      .expire   (ch_exp[c])
    );
  end

  cdt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .ien_we (bus_we && bus_addr == ADDR_W'(IEN_OFF)),
    .sts_we (bus_we && bus_addr == ADDR_W'(STS_OFF)),
    .wbits  (bus_wdata[NUM_CH-1:0]),
    .expire (ch_exp),
    .ien_q  (ien),
    .sts_q  (sts),
    .irq    (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(IEN_OFF)) rd_mux = CNT_W'(ien);
    if (bus_addr == ADDR_W'(STS_OFF)) rd_mux = CNT_W'(sts);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(CH_STRIDE * (c + 1) + CTRL_REL)) rd_mux = CNT_W'(ch_ctrl[c]);
      if (bus_addr == ADDR_W'(CH_STRIDE * (c + 1) + INTV_REL)) rd_mux = ch_intv[c];
      if (bus_addr == ADDR_W'(CH_STRIDE * (c + 1) + CNT_REL))  rd_mux = ch_cnt[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/cdtimer_top_tb_top.sv
module cdtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cdtimer_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_tick[s] = 1'b1;
      @(negedge clk); src_tick[s] = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl0", 8'h10, 0);
    rd_chk("R1 cnt0", 8'h18, 0);
    rd_chk("R1 status", 8'h04, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd_chk("R12 unmapped", 8'h0C, 0);
  endtask

  task automatic t_oneshot;
    wr(8'h14, 5);
    wr(8'h10, 32'h83);
    rd_chk("R3 reload bit reads 0", 8'h10, 32'h81);
    rd_chk("R3 count loaded", 8'h18, 5);
    ticks(0, 3);
    rd_chk("R4 decrement", 8'h18, 2);
    ticks(0, 2);
    rd_chk("R6 count zero", 8'h18, 0);
    rd_chk("R6 status set bit0", 8'h04, 1);
    rd_chk("R6 enable cleared", 8'h10, 32'h80);
    check("R10 irq masked", {31'b0, irq}, 0);
    ticks(0, 2);
    rd_chk("R6 stays stopped", 8'h18, 0);
  endtask

  task automatic t_irq_w1c;
    wr(8'h00, 1); idle(2);
    check("R10 irq raised", {31'b0, irq}, 1);
    wr(8'h04, 0);
    rd_chk("R9 write 0 no effect", 8'h04, 1);
    wr(8'h04, 1);
    rd_chk("R9 write 1 clears", 8'h04, 0);
    idle(2);
    check("R10 irq dropped", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic_disable;
    wr(8'h14, 3);
    wr(8'h10, 32'h03);
    ticks(0, 3);
    rd_chk("R7 status on expiry", 8'h04, 1);
    rd_chk("R7 reloaded", 8'h18, 3);
    rd_chk("R7 still enabled", 8'h10, 32'h01);
    ticks(0, 1);
    rd_chk("R7 keeps counting", 8'h18, 2);
    wr(8'h04, 1);
    wr(8'h10, 32'h00);
    ticks(0, 3);
    rd_chk("R8 count frozen", 8'h18, 2);
    rd_chk("R8 no expiry", 8'h04, 0);
  endtask

  task automatic t_prescale;
    wr(8'h24, 10);
    wr(8'h20, 32'h27);
    ticks(1, 3);
    rd_chk("R5 no tick before 4", 8'h28, 10);
    ticks(1, 1);
    rd_chk("R5 tick at 4th strobe", 8'h28, 9);
    ticks(0, 4);
    rd_chk("R5 other source ignored", 8'h28, 9);
    ticks(1, 4);
    rd_chk("R5 next divided tick", 8'h28, 8);
  endtask

  task automatic t_ch1_irq;
    wr(8'h24, 2);
    wr(8'h20, 32'h07);
    ticks(1, 2);
    rd_chk("R2 ch1 status bit1", 8'h04, 2);
    idle(2);
    check("R10 ch1 not enabled", {31'b0, irq}, 0);
    wr(8'h00, 3); idle(2);
    check("R10 ch1 enabled", {31'b0, irq}, 1);
    wr(8'h20, 32'h00);
    wr(8'h04, 2);
    rd_chk("R9 ch1 cleared", 8'h04, 0);
  endtask

  task automatic t_freerun;
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'h03);
    ticks(0, 2);
    rd_chk("R11 free-run count", 8'h18, 32'hFFFF_FFFD);
    bus_addr = 8'h18;
    check("R11 inverse is elapsed", ~bus_rdata, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_oneshot();
    t_irq_w1c();
    t_periodic_disable();
    t_prescale();
    t_ch1_irq();
    t_freerun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule